// File: doc/BRIEF.md
# DRAM Burst Column Order Generator

This block turns a single burst request into the per-beat column offsets of one DRAM burst. A request carries a starting column (three bits: the top bit selects the half of the eight-column group, the lower two select a word within the half), a read/write flag, a burst-length select (a full eight-beat burst or a four-beat chopped burst) and an ordering select (sequential wrap or XOR interleave). The block then steps through eight beat slots, one per clock. For each slot it gives a column index and a flag that says whether data is carried in that slot.

A chopped burst still takes all eight slots, so its timing matches a full burst. Only the first four slots carry data. Writes do not use every start bit. A chopped write uses only the half-select bit. A full write ignores the whole start column and always runs in natural order. A memory controller uses the block to index its beat buffers and to gate its data drivers.

Top module: `burst_col_order`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `slot_o`, `drive_o` and `done_o` are 0 and `col_o` is 0.
- R2: A start is accepted when `start_i` is 1 at a rising edge while `slot_o` is 0. Beat 0 appears on the next cycle, and `slot_o` is then 1 for exactly eight consecutive cycles.
- R3: For a read with `interleave_i`=0, beat b (0..7) carries column {s[2] XOR b[2], (s[1:0] + b[1:0]) mod 4}, where s is `start_col_i` (for example, start 5 gives 5,6,7,4,1,2,3,0).
- R4: For a read with `interleave_i`=1, beat b carries column s XOR b (for example, start 5 gives 5,4,7,6,1,0,3,2).
- R5: With `chop_i`=1, `drive_o` is 1 only in beats 0..3. In beats 4..7, `drive_o` is 0 and `col_o` is 0.
- R6: For a write with `chop_i`=1, bits 1 and 0 of the start column are treated as 0, so the driven beats are 0,1,2,3 when bit 2 is 0 and 4,5,6,7 when bit 2 is 1, for either ordering.
- R7: For a write with `chop_i`=0, the start column is ignored and the beats are 0,1,...,7 for either ordering.
- R8: A start request seen while `slot_o` is 1 has no effect on the running burst's columns, drive flags or length.
- R9: `done_o` is 1 only in the eighth beat slot of a burst.
- R10: With `chop_i`=0, `drive_o` is 1 in all eight beat slots.
- R11: Whenever `slot_o` is 0, `drive_o` is 0 and `col_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Burst request |
| start_col_i | input | COL_W | Starting column; the top bit selects the half |
| is_write_i | input | 1 | 1 = write, 0 = read |
| chop_i | input | 1 | 1 = four-beat chopped burst, 0 = full burst |
| interleave_i | input | 1 | 1 = XOR interleaved order, 0 = sequential wrap |
| slot_o | output | 1 | A beat slot is being presented |
| col_o | output | COL_W | Column index of the current beat |
| drive_o | output | 1 | Data is carried in this beat |
| done_o | output | 1 | Eighth (last) beat slot |

## Verification
Every output is registered once. After the edge that accepts a start, beat b is visible after the (b+1)-th rising edge. The slot after the burst goes idle one edge after beat 7. The bench drives inputs on falling edges and samples at the falling edge after each rising edge, so each beat is checked in the very cycle it is due. Requests made during a burst are held for several beats and are then released before the burst ends. Any effect they had would show up in the columns that are checked in those same cycles.

// File: rtl/bco_pkg.sv
package bco_pkg;
  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;
  typedef enum logic {LEN_FULL = 1'b0, LEN_CHOP = 1'b1} len_e;
  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;
endpackage

// File: rtl/bco_seq.sv
module bco_seq #(
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_in,
  input  logic             wr_in,
  input  logic             chop_in,
  input  logic             ilv_in,
  output logic             present,
  output logic [COL_W-1:0] beat_next,
  output logic             last_next,
  output logic [COL_W-1:0] col_use,
  output logic             wr_use,
  output logic             chop_use,
  output logic             ilv_use
);
  localparam logic [COL_W-1:0] LAST = '1;

  logic             active_q;
  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q, chop_q, ilv_q;
  logic             accept;

  assign accept = start_i && !active_q;

  always_comb begin
    present   = 1'b0;
    beat_next = '0;
    col_use   = col_q;
    wr_use    = wr_q;
    chop_use  = chop_q;
    ilv_use   = ilv_q;
    if (accept) begin
      present  = 1'b1;
      col_use  = col_in;
      wr_use   = wr_in;
      chop_use = chop_in;
      ilv_use  = ilv_in;
    end else if (active_q && cnt_q != LAST) begin
      present   = 1'b1;
      beat_next = cnt_q + 1'b1;
    end
  end

  assign last_next = present && (beat_next == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      col_q    <= '0;
      wr_q     <= 1'b0;
      chop_q   <= 1'b0;
      ilv_q    <= 1'b0;
    end else begin
      active_q <= present;
      cnt_q    <= beat_next;
      if (accept) begin
        col_q  <= col_in;
        wr_q   <= wr_in;
        chop_q <= chop_in;
        ilv_q  <= ilv_in;
      end
    end
  end

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    (active_q && cnt_q != LAST) |=> (active_q && cnt_q == $past(cnt_q) + 1'b1)) // R8
    else $error("beat counter did not advance");
endmodule

// File: rtl/bco_map.sv
module bco_map
  import bco_pkg::*;
#(
  parameter int COL_W = 3
) (
  input  logic [COL_W-1:0] col_s,
  input  logic             wr_s,
  input  logic             chop_s,
  input  logic             ilv_s,
  input  logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] col_out,
  output logic             drive_out
);
  localparam int LOW_W = COL_W - 1;

  logic [COL_W-1:0] eff;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;
  logic [LOW_W-1:0] low_sum;

  always_comb begin
    if (dir_e'(wr_s) == DIR_WR)
      eff = (len_e'(chop_s) == LEN_CHOP) ? {col_s[COL_W-1], {LOW_W{1'b0}}} : '0;
    else
      eff = col_s;
  end

  assign low_sum = eff[LOW_W-1:0] + beat[LOW_W-1:0];
  assign seq_col = {eff[COL_W-1] ^ beat[COL_W-1], low_sum};
  assign ilv_col = eff ^ beat;

  assign drive_out = (len_e'(chop_s) == LEN_FULL) || !beat[COL_W-1];
  assign col_out   = !drive_out ? '0 :
                     (order_e'(ilv_s) == ORD_ILV) ? ilv_col : seq_col;
endmodule

// File: rtl/burst_col_order.sv
module burst_col_order #(
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             is_write_i,
  input  logic             chop_i,
  input  logic             interleave_i,
  output logic             slot_o,
  output logic [COL_W-1:0] col_o,
  output logic             drive_o,
  output logic             done_o
);
  logic             present, last_next;
  logic [COL_W-1:0] beat_next, col_use, col_map;
  logic             wr_use, chop_use, ilv_use, drv_map;

  bco_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i),
    .col_in(start_col_i), .wr_in(is_write_i), .chop_in(chop_i), .ilv_in(interleave_i),
    .present(present), .beat_next(beat_next), .last_next(last_next),
    .col_use(col_use), .wr_use(wr_use), .chop_use(chop_use), .ilv_use(ilv_use)
  );

  bco_map #(.COL_W(COL_W)) u_map (
    .col_s(col_use), .wr_s(wr_use), .chop_s(chop_use), .ilv_s(ilv_use),
    .beat(beat_next), .col_out(col_map), .drive_out(drv_map)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_o  <= 1'b0;
      col_o   <= '0;
      drive_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      slot_o  <= present;
      col_o   <= present ? col_map : '0;
      drive_o <= present && drv_map;
      done_o  <= last_next;
    end
  end

  AST_DONE_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> slot_o) // R9
    else $error("done outside a slot");
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !slot_o) // R2
    else $error("slot continued after done");
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !slot_o |-> (!drive_o && col_o == '0)) // R11
    else $error("idle outputs not quiet");
  AST_START_BEAT: assert property (@(posedge clk) disable iff (rst)
    (start_i && !slot_o) |=> (slot_o && !done_o)) // R2
    else $error("accepted start gave no first beat");
  AST_MID_CONTINUES: assert property (@(posedge clk) disable iff (rst)
    (slot_o && !done_o) |=> slot_o) // R8
    else $error("burst cut short");
endmodule

// File: tb/burst_col_order_bench.sv
module burst_col_order_bench;
  localparam int COL_W = 3;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic is_write_i = 1'b0, chop_i = 1'b0, interleave_i = 1'b0;
  logic slot_o, drive_o, done_o;
  logic [COL_W-1:0] col_o;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  burst_col_order #(.COL_W(COL_W)) u_burst_col_order (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .is_write_i(is_write_i), .chop_i(chop_i), .interleave_i(interleave_i),
    .slot_o(slot_o), .col_o(col_o), .drive_o(drive_o), .done_o(done_o)
  );

  function automatic logic [2:0] exp_col(logic [2:0] s, logic wr, logic ch, logic il, int b);
    logic [2:0] e;
    logic [2:0] bb;
    bb = 3'(b);
    if (wr) e = ch ? {s[2], 2'b00} : 3'd0;   // R6 / R7
    else e = s;
    if (ch && b >= 4) return 3'd0;           // R5
    if (il) return e ^ bb;                   // R4
    return {e[2] ^ bb[2], 2'(e[1:0] + bb[1:0])}; // R3
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_burst(logic [2:0] s, logic wr, logic ch, logic il, bit poke);
    @(negedge clk);
    start_i = 1'b1; start_col_i = s; is_write_i = wr; chop_i = ch; interleave_i = il;
    @(posedge clk); @(negedge clk);
    if (poke) begin  // R8: new request with different fields during the burst
      start_col_i = ~s; is_write_i = ~wr; chop_i = ~ch; interleave_i = ~il;
    end else start_i = 1'b0;
    for (int b = 0; b < 8; b++) begin
      if (b == 4) start_i = 1'b0;
      chk("R2 slot", slot_o, 1);
      chk(wr ? (ch ? "R6 col" : "R7 col") : (il ? "R4 col" : "R3 col"),
          col_o, exp_col(s, wr, ch, il, b));
      chk(ch ? "R5 drive" : "R10 drive", drive_o, (!ch || b < 4) ? 1 : 0);
      chk("R9 done", done_o, (b == 7) ? 1 : 0);
      @(posedge clk); @(negedge clk);
    end
    chk("R11 slot", slot_o, 0);
    chk("R11 drive", drive_o, 0);
    chk("R11 col", col_o, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 slot", slot_o, 0); chk("R1 drive", drive_o, 0);
    chk("R1 done", done_o, 0); chk("R1 col", col_o, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 slot after release", slot_o, 0);
    run_burst(3'd5, 0, 0, 0, 0); // R3
    run_burst(3'd5, 0, 0, 1, 0); // R4
    run_burst(3'd6, 0, 1, 0, 0); // R5
    run_burst(3'd3, 0, 1, 1, 0); // R5
    run_burst(3'd7, 1, 1, 0, 0); // R6
    run_burst(3'd3, 1, 1, 1, 0); // R6
    run_burst(3'd5, 1, 0, 1, 0); // R7
    run_burst(3'd2, 1, 0, 0, 0); // R7
    run_burst(3'd1, 0, 0, 0, 1); // R8
    for (int i = 0; i < 40; i++)
      run_burst(3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule